// File: doc/BRIEF.md
# Chroma Interpolating Quadrature Modulator

This block turns a pair of baseband colour-difference streams into a chroma-on-subcarrier signal. The two streams are the blue difference (U) and the red difference (V). Each arrives at one quarter of the system clock rate. An input strobe marks each new pair, and a new pair must come on every fourth clock.

Each component is first scaled by its own gain. During the burst region the picture is replaced by a colour burst on the negative U axis. The burst amplitude rises and falls linearly over a few samples.

The block then raises the sample rate by four using two cascaded 2x linear stages. Setting the bypass control replaces the second stage with sample repetition, which gives a wider colour bandwidth. A phase-accumulator subcarrier with a folded quarter-wave sine table then drives a quadrature modulator. Its result is rounded and clamped to a signed 10-bit output.

Top module: `chroma_modulator`

## Requirements
- R1: While rst_n is low, chroma_out is 0 and the subcarrier phase accumulator is cleared.
- R2: On a strobe, the U sample is floor((cb_in*gain_cb + 32)/64), where cb_in is a signed two's complement 8-bit value and gain_cb is unsigned with 64 meaning unity.
- R3: The V sample is formed the same way from cr_in and gain_cr, independently of the U gain.
- R4: During a burst region, the stored sample has V = 0 and U = -floor(burst_amp*r/4), where r is the updated ramp step, and the picture input is discarded.
- R5: The ramp step goes up by one on each strobe with burst_win high, up to 4. It goes down by one on each strobe with burst_win low, down to 0. A strobe is a burst strobe if burst_win is high or the previous step was non-zero. So the levels are 1/4, 2/4, 3/4 and 4/4 at the start, and 3/4, 2/4, 1/4 and 0 after the window ends. The picture resumes on the fifth strobe after the window.
- R6: With a the previous stored sample and b the latest, the four baseband outputs for that period are floor((3a+b)/4), floor((a+b)/2), floor((a+3b)/4) and b, in that order.
- R7: With bypass_s2 high, the four outputs are floor((a+b)/2) twice, then b twice.
- R8: Output k (k = 0..3) of a period appears on chroma_out after the (2+k)-th rising edge following the edge that took the strobe.
- R9: The 32-bit phase accumulator adds phase_inc on every clock. Its top 8 bits select one of 256 equal subcarrier angles, and angle 0 means sine 0 and cosine 1.
- R10: chroma_out = floor((U*S + V*C + 256)/512), where S and C are 511 times the sine and cosine of the angle. The result is exact at angles 0, 64, 128 and 192, and within 3 LSB elsewhere. The angle used is the one held during the cycle before the output edge.
- R11: Results above 511 are clamped to 511, and results below -512 are clamped to -512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (four times the sample rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe for a new U/V pair, once every fourth clock |
| cb_in | input | 8 | Signed blue-difference sample |
| cr_in | input | 8 | Signed red-difference sample |
| gain_cb | input | 8 | Unsigned U gain, 64 = unity |
| gain_cr | input | 8 | Unsigned V gain, 64 = unity |
| burst_win | input | 1 | High for samples inside the burst window |
| burst_amp | input | 8 | Full burst amplitude |
| bypass_s2 | input | 1 | Replace the second interpolation stage with repetition |
| phase_inc | input | 32 | Subcarrier phase step per clock |
| chroma_out | output | 10 | Signed modulated chroma |

## Verification
A strobe taken at edge E affects chroma_out first after edge E+2. The four interpolated results of that period then follow one per edge, up to E+5. The bench runs a reference model that advances on the same edges: one stage stores the sample, one stage registers the baseband, and one stage registers the modulator. It compares every output at the falling edge after it is due. Setting phase_inc to 0 makes the output equal the V path alone. Setting it to a quarter turn shows U and V on alternate edges. Both settings allow exact checks of the gain, burst-ramp and interpolation sequences. Arbitrary phase steps are checked within the stated tolerance.

// File: rtl/chroma_pkg.sv
package chroma_pkg;
  localparam int BB_W = 10;

  typedef struct packed {
    logic [BB_W-1:0] u;
    logic [BB_W-1:0] v;
  } cpair_t;
endpackage

// File: rtl/chroma_prep.sv
module chroma_prep
  import chroma_pkg::*;
#(
  parameter int IN_W      = 8,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 6,
  parameter int AMP_W     = 8,
  parameter int RAMP_SH   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   cb_in,
  input  logic [IN_W-1:0]   cr_in,
  input  logic [GAIN_W-1:0] gain_cb,
  input  logic [GAIN_W-1:0] gain_cr,
  input  logic              burst_win,
  input  logic [AMP_W-1:0]  burst_amp,
  output cpair_t            x_prev,
  output cpair_t            x_cur
);
  localparam int RAMP_LEN = 1 << RAMP_SH;
  localparam int RW       = RAMP_SH + 1;
  localparam int PW       = IN_W + GAIN_W + 1;
  localparam int LW       = AMP_W + RW;

  logic [RW-1:0] ramp_q, ramp_d;
  logic          in_burst;
  logic [LW-1:0] burst_prod, burst_lvl;
  cpair_t        cur_q, prev_q, cur_d;

  function automatic logic [BB_W-1:0] apply_gain(input logic [IN_W-1:0] s,
                                                 input logic [GAIN_W-1:0] g);
    logic signed [PW-1:0] p;
    p = $signed(s) * $signed({1'b0, g});
    p = p + PW'(2 ** (GAIN_FRAC - 1));
    return BB_W'(p >>> GAIN_FRAC);
  endfunction

  // next-state: ramp step and stored sample
  always_comb begin
    if (burst_win) begin
      ramp_d = (ramp_q == RW'(RAMP_LEN)) ? ramp_q : ramp_q + RW'(1);
    end else begin
      ramp_d = (ramp_q == '0) ? ramp_q : ramp_q - RW'(1);
    end
    in_burst   = burst_win || (ramp_q != '0);
    burst_prod = LW'(burst_amp) * LW'(ramp_d);
    burst_lvl  = burst_prod >> RAMP_SH;
    if (in_burst) begin
      cur_d.u = -BB_W'(burst_lvl);
      cur_d.v = '0;
    end else begin
      cur_d.u = apply_gain(cb_in, gain_cb);
      cur_d.v = apply_gain(cr_in, gain_cr);
    end
  end

  // registers, enabled by the input strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else if (in_valid) begin
      ramp_q <= ramp_d;
      cur_q  <= cur_d;
      prev_q <= cur_q;
    end
  end

  assign x_prev = prev_q;
  assign x_cur  = cur_q;

  AST_RAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(ramp_q)) else $error("ramp moved without strobe"); // R5
  AST_RAMP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && burst_win) |=> (ramp_q != '0)) else $error("ramp zero in window"); // R5
  AST_BURST_V_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && burst_win) |=> (cur_q.v == '0)) else $error("V not zero in burst"); // R4
endmodule

// File: rtl/chroma_interp.sv
module chroma_interp
  import chroma_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  logic   bypass_s2,
  input  cpair_t x_prev,
  input  cpair_t x_cur,
  output cpair_t bb_o
);
  localparam int NLANE = 2;

  logic [1:0]      ph_q, ph_d;
  logic [BB_W-1:0] xa [NLANE];
  logic [BB_W-1:0] xb [NLANE];
  cpair_t          bb_q, bb_d;

  function automatic logic [BB_W-1:0] avg2(input logic [BB_W-1:0] a,
                                           input logic [BB_W-1:0] b);
    logic signed [BB_W:0] s;
    s = $signed({a[BB_W-1], a}) + $signed({b[BB_W-1], b});
    return BB_W'(s >>> 1);
  endfunction

  assign xa[0] = x_prev.u;
  assign xa[1] = x_prev.v;
  assign xb[0] = x_cur.u;
  assign xb[1] = x_cur.v;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    logic [BB_W-1:0] h_mid, h_end, y;
    // first 2x stage: midpoint then new sample
    assign h_mid = avg2(xa[k], xb[k]);
    assign h_end = xb[k];
    // second 2x stage, or repetition when bypassed
    always_comb begin
      unique case (ph_q)
        2'd0:    y = bypass_s2 ? h_mid : avg2(xa[k], h_mid);
        2'd1:    y = h_mid;
        2'd2:    y = bypass_s2 ? h_end : avg2(h_mid, h_end);
        default: y = h_end;
      endcase
    end
  end

  always_comb begin
    ph_d   = in_valid ? 2'd0 : ph_q + 2'd1;
    bb_d.u = g_lane[0].y;
    bb_d.v = g_lane[1].y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      bb_q <= '0;
    end else begin
      ph_q <= ph_d;
      bb_q <= bb_d;
    end
  end

  assign bb_o = bb_q;

  AST_BYPASS_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == 2'd1 && bypass_s2 && $past(bypass_s2)) |=> (bb_q == $past(bb_q)))
    else $error("bypass did not repeat"); // R7
  AST_END_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == 2'd3) |=> (bb_q == $past(x_cur))) else $error("last phase not newest sample"); // R6
endmodule

// File: rtl/chroma_nco.sv
module chroma_nco #(
  parameter int ACC_W  = 32,
  parameter int LUT_AW = 6,
  parameter int SIN_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ACC_W-1:0]        phase_inc,
  output logic signed [SIN_W-1:0] sin_o,
  output logic signed [SIN_W-1:0] cos_o
);
  localparam int QTR = 1 << LUT_AW;
  localparam int AMP = (1 << (SIN_W - 1)) - 1;

  logic [ACC_W-1:0]        acc_q, acc_d;
  logic [LUT_AW+1:0]       ang;
  logic [SIN_W-1:0]        lut [0:QTR];
  logic signed [SIN_W-1:0] wave [2];

  // rational sine approximation over one quarter turn, rounded
  function automatic int sin_entry(input int k);
    longint p, t, num, den;
    p   = 2 * QTR;
    t   = longint'(k) * (p - longint'(k));
    num = 16 * t;
    den = 5 * p * p - 4 * t;
    return int'((longint'(AMP) * num + den / 2) / den);
  endfunction

  for (genvar k = 0; k <= QTR; k++) begin : g_lut
    assign lut[k] = SIN_W'(sin_entry(k));
  end

  assign ang = acc_q[ACC_W-1 -: LUT_AW+2];

  // axis 0 = sine, axis 1 = cosine (a quarter turn ahead)
  for (genvar c = 0; c < 2; c++) begin : g_axis
    logic [1:0]       quad;
    logic [LUT_AW:0]  addr;
    logic [SIN_W-1:0] mag;
    assign quad    = ang[LUT_AW+1:LUT_AW] + 2'(c);
    assign addr    = quad[0] ? (LUT_AW+1)'(QTR) - {1'b0, ang[LUT_AW-1:0]}
                             : {1'b0, ang[LUT_AW-1:0]};
    assign mag     = lut[addr];
    assign wave[c] = quad[1] ? -$signed(mag) : $signed(mag);
  end

  assign sin_o = wave[0];
  assign cos_o = wave[1];

  always_comb acc_d = acc_q + phase_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  AST_ANGLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ang == '0) |-> (sin_o == '0 && cos_o == SIN_W'(AMP))) else $error("angle 0 wrong"); // R9
  AST_ANGLE_QTR: assert property (@(posedge clk) disable iff (!rst_n)
    (ang == (LUT_AW+2)'(QTR)) |-> (sin_o == SIN_W'(AMP) && cos_o == '0)) else $error("quarter wrong"); // R10
endmodule

// File: rtl/chroma_qmod.sv
module chroma_qmod
  import chroma_pkg::*;
#(
  parameter int SIN_W = 10,
  parameter int OUT_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  cpair_t                  bb_i,
  input  logic signed [SIN_W-1:0] sin_i,
  input  logic signed [SIN_W-1:0] cos_i,
  output logic [OUT_W-1:0]        out_o
);
  localparam int MW = BB_W + SIN_W + 1;
  localparam int SH = SIN_W - 1;
  localparam logic signed [MW-1:0] HALF = MW'(1 << (SH - 1));
  localparam logic signed [MW-1:0] MAXV = MW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [MW-1:0] MINV = -MW'(1 << (OUT_W - 1));

  logic signed [MW-1:0] mac, rnd;
  logic [OUT_W-1:0]     out_q, out_d;

  always_comb begin
    mac = $signed(bb_i.u) * sin_i + $signed(bb_i.v) * cos_i;
    rnd = (mac + HALF) >>> SH;
    if (rnd > MAXV)      out_d = OUT_W'(MAXV);
    else if (rnd < MINV) out_d = OUT_W'(MINV);
    else                 out_d = OUT_W'(rnd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign out_o = out_q;

  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (bb_i == '0) |=> (out_q == '0)) else $error("zero baseband gave output"); // R10
endmodule

// File: rtl/chroma_modulator.sv
module chroma_modulator
  import chroma_pkg::*;
#(
  parameter int IN_W   = 8,
  parameter int GAIN_W = 8,
  parameter int AMP_W  = 8,
  parameter int ACC_W  = 32,
  parameter int LUT_AW = 6,
  parameter int OUT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   cb_in,
  input  logic [IN_W-1:0]   cr_in,
  input  logic [GAIN_W-1:0] gain_cb,
  input  logic [GAIN_W-1:0] gain_cr,
  input  logic              burst_win,
  input  logic [AMP_W-1:0]  burst_amp,
  input  logic              bypass_s2,
  input  logic [ACC_W-1:0]  phase_inc,
  output logic [OUT_W-1:0]  chroma_out
);
  localparam int SIN_W = OUT_W;

  cpair_t                  x_prev, x_cur, bb;
  logic signed [SIN_W-1:0] sin_v, cos_v;

  chroma_prep #(
    .IN_W(IN_W), .GAIN_W(GAIN_W), .GAIN_FRAC(6), .AMP_W(AMP_W), .RAMP_SH(2)
  ) u_prep (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .cb_in(cb_in), .cr_in(cr_in), .gain_cb(gain_cb), .gain_cr(gain_cr),
    .burst_win(burst_win), .burst_amp(burst_amp),
    .x_prev(x_prev), .x_cur(x_cur)
  );

  chroma_interp u_interp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bypass_s2(bypass_s2),
    .x_prev(x_prev), .x_cur(x_cur), .bb_o(bb)
  );

  chroma_nco #(
    .ACC_W(ACC_W), .LUT_AW(LUT_AW), .SIN_W(SIN_W)
  ) u_nco (
    .clk(clk), .rst_n(rst_n), .phase_inc(phase_inc), .sin_o(sin_v), .cos_o(cos_v)
  );

  chroma_qmod #(
    .SIN_W(SIN_W), .OUT_W(OUT_W)
  ) u_qmod (
    .clk(clk), .rst_n(rst_n), .bb_i(bb), .sin_i(sin_v), .cos_i(cos_v),
    .out_o(chroma_out)
  );

  AST_RESET_OUT: assert property (@(posedge clk) $fell(rst_n) |-> (chroma_out == '0))
    else $error("output not cleared"); // R1
endmodule

// File: tb/tb_chroma_modulator.sv
module tb_chroma_modulator;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  cb_in, cr_in, gain_cb, gain_cr, burst_amp;
  logic        burst_win, bypass_s2;
  logic [31:0] phase_inc;
  logic [9:0]  chroma_out;

  int    errors = 0;
  int    checks = 0;
  bit    chk_en = 1'b0;
  bit    done   = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  chroma_modulator dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cb_in(cb_in), .cr_in(cr_in),
    .gain_cb(gain_cb), .gain_cr(gain_cr), .burst_win(burst_win),
    .burst_amp(burst_amp), .bypass_s2(bypass_s2), .phase_inc(phase_inc),
    .chroma_out(chroma_out)
  );

  // reference model state
  int          m_ramp, m_xpu, m_xpv, m_xcu, m_xcv, m_ph, m_bbu, m_bbv, m_eu, m_ev;
  logic [31:0] m_acc;
  logic [7:0]  m_eang;

  function automatic int gain_model(input logic [7:0] s, input logic [7:0] g);
    return (int'($signed(s)) * int'(g) + 32) >>> 6;
  endfunction

  function automatic int interp_model(input int a, input int b, input int ph, input bit byp);
    case (ph)
      0:       return byp ? (a + b) >>> 1 : (3 * a + b) >>> 2;
      1:       return (a + b) >>> 1;
      2:       return byp ? b : (a + 3 * b) >>> 2;
      default: return b;
    endcase
  endfunction

  function automatic int clamp10(input int x);
    if (x > 511) return 511;
    if (x < -512) return -512;
    return x;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ramp <= 0; m_xpu <= 0; m_xpv <= 0; m_xcu <= 0; m_xcv <= 0;
      m_ph <= 0; m_bbu <= 0; m_bbv <= 0; m_eu <= 0; m_ev <= 0;
      m_acc <= '0; m_eang <= '0;
    end else begin
      if (in_valid) begin
        int nr;
        nr = burst_win ? ((m_ramp < 4) ? m_ramp + 1 : 4) : ((m_ramp > 0) ? m_ramp - 1 : 0);
        m_ramp <= nr;
        m_xpu <= m_xcu;
        m_xpv <= m_xcv;
        if (burst_win || m_ramp != 0) begin
          m_xcu <= -((int'(burst_amp) * nr) >> 2);
          m_xcv <= 0;
        end else begin
          m_xcu <= gain_model(cb_in, gain_cb);
          m_xcv <= gain_model(cr_in, gain_cr);
        end
      end
      m_ph  <= in_valid ? 0 : (m_ph + 1) % 4;
      m_bbu <= interp_model(m_xpu, m_xcu, m_ph, bypass_s2);
      m_bbv <= interp_model(m_xpv, m_xcv, m_ph, bypass_s2);
      m_eu  <= m_bbu;
      m_ev  <= m_bbv;
      m_eang <= m_acc[31:24];
      m_acc <= m_acc + phase_inc;
    end
  end

  task automatic check_out(input string req);
    int  act, exp_v, tol;
    real th, rv;
    act = int'($signed(chroma_out));
    if (m_eang[5:0] == 6'd0) begin
      int s, c;
      case (m_eang[7:6])
        2'd0: begin s = 0;    c = 511;  end
        2'd1: begin s = 511;  c = 0;    end
        2'd2: begin s = 0;    c = -511; end
        default: begin s = -511; c = 0; end
      endcase
      exp_v = clamp10((m_eu * s + m_ev * c + 256) >>> 9);
      tol = 0;
    end else begin
      th = 2.0 * 3.14159265358979 * real'(int'(m_eang)) / 256.0;
      rv = (real'(m_eu) * 511.0 * $sin(th) + real'(m_ev) * 511.0 * $cos(th)) / 512.0;
      exp_v = clamp10(int'($floor(rv + 0.5)));
      tol = 3;
    end
    checks++;
    if (act - exp_v > tol || exp_v - act > tol) begin
      errors++;
      $display("FAIL %s: chroma_out=%0d expected=%0d (tol %0d) at %0t", req, act, exp_v, tol, $time);
    end
  endtask

  always @(negedge clk) if (chk_en && rst_n) check_out(cur_req);

  task automatic send(input logic [7:0] cb, input logic [7:0] cr, input bit win);
    @(negedge clk);
    cb_in = cb; cr_in = cr; burst_win = win; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_rand(input int n);
    for (int i = 0; i < n; i++) send(8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)), 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; cb_in = '0; cr_in = '0;
    gain_cb = 8'd64; gain_cr = 8'd64; burst_win = 1'b0; burst_amp = '0;
    bypass_s2 = 1'b0; phase_inc = '0;
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (chroma_out !== 10'd0) begin
        errors++;
        $display("FAIL R1: chroma_out=%0d expected=0 in reset", chroma_out);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
    chk_en = 1'b1;

    // R3 R6 R8: V path alone with zero phase step, random gains
    cur_req = "R3 R6 R8";
    for (int blk = 0; blk < 5; blk++) begin
      gain_cr = 8'($urandom_range(0, 255));
      gain_cb = 8'($urandom_range(0, 255));
      send_rand(8);
    end

    // R6 R8: directed V steps, largest swing
    cur_req = "R6 R8";
    gain_cr = 8'd64;
    repeat (4) send(8'd0, 8'd0, 1'b0);
    repeat (4) send(8'd0, 8'd100, 1'b0);
    repeat (2) send(8'd0, 8'h9c, 1'b0);
    send(8'd0, 8'h7f, 1'b0);
    send(8'd0, 8'h80, 1'b0);

    // R2: quarter-turn step so U is seen on alternate edges
    cur_req = "R2 R10";
    phase_inc = 32'h4000_0000;
    for (int blk = 0; blk < 5; blk++) begin
      gain_cb = 8'($urandom_range(0, 255));
      send_rand(8);
    end

    // R7: second stage bypassed, then toggled mid-stream
    cur_req = "R7";
    phase_inc = 32'd0;
    bypass_s2 = 1'b1;
    send_rand(16);
    for (int i = 0; i < 16; i++) begin
      bypass_s2 = 1'($urandom_range(0, 1));
      send(8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)), 1'b0);
    end
    bypass_s2 = 1'b0;

    // R4 R5: burst window with ramp in and out, U visible
    cur_req = "R4 R5";
    phase_inc = 32'h4000_0000;
    gain_cb = 8'd64; gain_cr = 8'd64;
    burst_amp = 8'd200;
    repeat (3) send(8'd50, 8'd40, 1'b0);
    repeat (8) send(8'd50, 8'd40, 1'b1);
    repeat (8) send(8'd50, 8'd40, 1'b0);
    burst_amp = 8'd255;
    repeat (2) send(8'd20, 8'hf0, 1'b1);
    repeat (6) send(8'd20, 8'hf0, 1'b0);

    // R11: saturation on both signs at eighth-turn angles
    cur_req = "R11";
    phase_inc = 32'h2000_0000;
    gain_cb = 8'd255; gain_cr = 8'd255;
    repeat (6) send(8'h7f, 8'h7f, 1'b0);
    repeat (6) send(8'h80, 8'h80, 1'b0);

    // R9 R10: arbitrary phase steps with random samples
    cur_req = "R9 R10";
    for (int blk = 0; blk < 8; blk++) begin
      phase_inc = $urandom();
      gain_cb = 8'($urandom_range(0, 255));
      gain_cr = 8'($urandom_range(0, 255));
      bypass_s2 = 1'($urandom_range(0, 1));
      send_rand(8);
    end

    repeat (4) @(negedge clk);
    chk_en = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule